// File: doc/BRIEF.md
# Qualified Rising-Edge Detector for an Asynchronous Interrupt Pin

This block accepts a raw interrupt pin that may toggle with no timing relation to the local clock and turns a valid low-to-high transition into a single-cycle pulse for the interrupt recognition logic downstream. The pin first passes through a chain of synchronizing registers. The synchronized level is then judged against two windows. The pin must have been low for a minimum number of consecutive samples before it rises. It must then stay high for a minimum number of consecutive samples, counting the first high sample.

An edge that meets both windows produces exactly one pulse, in the cycle in which the high window completes. A pin that falls back before the high window completes has its candidate edge dropped. The low-time count then starts again from zero. The synchronizer depth and both window lengths are parameters. The block is placed once, between the interrupt pin pad and the core's interrupt sequencer.

Top module: `irq_edge_qualifier`

## Requirements
- R1: The pin is sampled on each rising clock edge through SYNC_STAGES register stages. A pulse is only ever produced by a low-to-high transition, so a pin held constant at either level never produces one.
- R2: While reset is high, edge_pulse_o is 0. After reset the pin counts as not yet qualified low, so a pin that is already high when reset is released produces no pulse.
- R3: A rising transition is only a candidate if the pin was sampled low on at least LOW_CYCLES consecutive clock edges just before the first high sample. With fewer low samples, no pulse follows.
- R4: A candidate edge qualifies only if the pin is sampled high on at least HIGH_CYCLES consecutive edges, counting the first high sample. If it falls earlier, the candidate is discarded and no pulse follows.
- R5: A qualified edge drives edge_pulse_o high for exactly one clock cycle. Counting the edge that first samples the pin high as edge 1, the pulse appears after edge SYNC_STAGES+HIGH_CYCLES.
- R6: One qualified edge yields exactly one pulse, however long the pin then stays high.
- R7: After a discarded candidate or a pulse, the next rising transition needs a fresh low run of LOW_CYCLES samples. Low samples taken before the previous rise do not count toward it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_i | input | 1 | Synchronous active-high reset |
| pin_async_i | input | 1 | Raw interrupt pin, asynchronous to clk_i |
| edge_pulse_o | output | 1 | One-cycle pulse for each qualified rising edge |

## Verification
The bench builds the block with its defaults: two synchronizer stages and windows of eight low and eight high samples. With eight-sample windows, the bench can drive low and high runs of seven and eight samples and so land on both sides of each threshold. The pulse's fixed latency, ten edges after the first high sample, can be checked exactly. The window is also long enough to let a short glitch pass through the synchronizer and reach the judging logic as a real candidate that must then be thrown away.

// File: rtl/edgeq_pkg.sv
package edgeq_pkg;

    typedef enum logic {
        JUDGE_ARMED = 1'b0,
        JUDGE_HIGH  = 1'b1
    } judge_mode_e;

    function automatic int unsigned cnt_width(input int unsigned max_val);
        return (max_val < 2) ? 1 : $clog2(max_val + 1);
    endfunction

endpackage

// File: rtl/edgeq_sync.sv
module edgeq_sync #(
    parameter int unsigned STAGES    = 2,
    parameter logic        RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= {STAGES{RESET_VAL}};
        end else begin
            chain_q[0] <= d_async;
            for (int i = 1; i < int'(STAGES); i++) begin
                chain_q[i] <= chain_q[i-1];
            end
        end
    end

    assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/edgeq_run_counter.sv
module edgeq_run_counter
    import edgeq_pkg::*;
#(
    parameter int unsigned MAX = 8,
    localparam int unsigned W  = cnt_width(MAX)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] count,
    output logic         full
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            count <= '0;
        end else if (inc && (count != W'(MAX))) begin
            count <= count + W'(1);
        end
    end

    assign full = (count == W'(MAX));
endmodule

// File: rtl/edgeq_judge.sv
module edgeq_judge
    import edgeq_pkg::*;
#(
    parameter int unsigned HIGH_CYCLES = 8,
    localparam int unsigned HW         = cnt_width(HIGH_CYCLES)
) (
    input  logic clk,
    input  logic rst,
    input  logic lvl,
    input  logic low_ready,
    output logic fire
);
    judge_mode_e    mode_q, mode_d;
    logic [HW-1:0]  hcnt_q, hcnt_d;
    logic [HW-1:0]  hcnt_next;
    logic           in_run;
    logic           fire_d;

    always_comb begin
        in_run    = lvl && ((mode_q == JUDGE_HIGH) || low_ready);
        hcnt_next = ((mode_q == JUDGE_HIGH) ? hcnt_q : '0) + HW'(1);
        fire_d    = in_run && (hcnt_next == HW'(HIGH_CYCLES));
        if (in_run && !fire_d) begin
            mode_d = JUDGE_HIGH;
            hcnt_d = hcnt_next;
        end else begin
            mode_d = JUDGE_ARMED;
            hcnt_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= JUDGE_ARMED;
            hcnt_q <= '0;
            fire   <= 1'b0;
        end else begin
            mode_q <= mode_d;
            hcnt_q <= hcnt_d;
            fire   <= fire_d;
        end
    end
endmodule

// File: rtl/irq_edge_qualifier.sv
module irq_edge_qualifier
    import edgeq_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned LOW_CYCLES  = 8,
    parameter int unsigned HIGH_CYCLES = 8
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic pin_async_i,
    output logic edge_pulse_o
);
    localparam int unsigned LW = cnt_width(LOW_CYCLES);

    logic          sync_lvl;
    logic [LW-1:0] low_count;
    logic          low_full;

    edgeq_sync #(
        .STAGES    (SYNC_STAGES),
        .RESET_VAL (1'b1)
    ) u_sync (
        .clk     (clk_i),
        .rst     (rst_i),
        .d_async (pin_async_i),
        .q_sync  (sync_lvl)
    );

    edgeq_run_counter #(
        .MAX (LOW_CYCLES)
    ) u_low_run (
        .clk   (clk_i),
        .rst   (rst_i),
        .clr   (sync_lvl),
        .inc   (!sync_lvl),
        .count (low_count),
        .full  (low_full)
    );

    edgeq_judge #(
        .HIGH_CYCLES (HIGH_CYCLES)
    ) u_judge (
        .clk       (clk_i),
        .rst       (rst_i),
        .lvl       (sync_lvl),
        .low_ready (low_full),
        .fire      (edge_pulse_o)
    );
endmodule

// File: rtl/edgeq_checker.sv
module edgeq_checker #(
    parameter int unsigned LOW_CYCLES  = 8,
    parameter int unsigned HIGH_CYCLES = 8
) (
    input logic clk,
    input logic rst,
    input logic sync_lvl,
    input logic pulse
);
    logic [15:0] hi_run, lo_run, lo_at_rise;
    logic        prev_lvl;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_run     <= '0;
            lo_run     <= '0;
            lo_at_rise <= '0;
            prev_lvl   <= 1'b1;
        end else begin
            prev_lvl <= sync_lvl;
            if (sync_lvl) begin
                lo_run <= '0;
                if (hi_run != 16'hFFFF) hi_run <= hi_run + 16'd1;
                if (!prev_lvl) lo_at_rise <= lo_run;
            end else begin
                hi_run <= '0;
                if (lo_run != 16'hFFFF) lo_run <= lo_run + 16'd1;
            end
        end
    end

    // R1: a pulse follows a high synchronized sample
    p_from_high_r1: assert property (@(posedge clk) disable iff (rst)
        pulse |-> $past(sync_lvl));

    // R2: quiet output after a reset cycle
    p_reset_quiet_r2: assert property (@(posedge clk)
        rst |=> !pulse);

    // R3: enough low samples preceded the rise
    p_low_window_r3: assert property (@(posedge clk) disable iff (rst)
        pulse |-> (lo_at_rise >= 16'(LOW_CYCLES)));

    // R4: enough high samples before the pulse
    p_high_window_r4: assert property (@(posedge clk) disable iff (rst)
        pulse |-> (hi_run >= 16'(HIGH_CYCLES)));

    // R5: pulse lasts a single cycle
    p_one_cycle_r5: assert property (@(posedge clk) disable iff (rst)
        pulse |=> !pulse);
endmodule

bind irq_edge_qualifier edgeq_checker #(
    .LOW_CYCLES  (LOW_CYCLES),
    .HIGH_CYCLES (HIGH_CYCLES)
) u_edgeq_chk (
    .clk      (clk_i),
    .rst      (rst_i),
    .sync_lvl (sync_lvl),
    .pulse    (edge_pulse_o)
);

// File: tb/irq_edge_qualifier_test.sv
module irq_edge_qualifier_test;
    localparam int S = 2;
    localparam int L = 8;
    localparam int H = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pin = 1'b1;
    logic pulse;

    int checks = 0;
    int fails  = 0;
    int tick   = 0;
    int pulses = 0;
    int last_pulse_tick = -1;
    bit done = 0;

    always #2 clk = ~clk;

    irq_edge_qualifier #(
        .SYNC_STAGES (S),
        .LOW_CYCLES  (L),
        .HIGH_CYCLES (H)
    ) uut (
        .clk_i        (clk),
        .rst_i        (rst),
        .pin_async_i  (pin),
        .edge_pulse_o (pulse)
    );

    task automatic check(input bit ok, input string req, input int actual, input int expected);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
        end
    endtask

    // one negedge per sample: observe output, then set the pin for the next posedge
    task automatic apply(input logic v, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (pulse) begin
                pulses++;
                last_pulse_tick = tick;
            end
            pin = v;
            tick++;
        end
    endtask

    task automatic run_case(input string req, input int low_n, input int high_n, input int exp_n);
        int p0, rise;
        apply(1'b1, 1);
        apply(1'b0, low_n);
        p0   = pulses;
        rise = tick;
        apply(1'b1, high_n);
        apply(1'b0, 14);
        check(pulses - p0 == exp_n, req, pulses - p0, exp_n);
        if (exp_n == 1)
            check(last_pulse_tick - rise == S + H, {req, " latency"}, last_pulse_tick - rise, S + H);
    endtask

    task automatic test_reset();
        int p0;
        rst = 1'b1;
        pin = 1'b1;
        repeat (4) begin
            @(negedge clk);
            check(pulse == 1'b0, "R2 in reset", int'(pulse), 0);
        end
        rst = 1'b0;
        p0 = pulses;
        apply(1'b1, 30);
        check(pulses - p0 == 0, "R2 high at reset", pulses - p0, 0);
    endtask

    task automatic test_const_low();
        int p0;
        p0 = pulses;
        apply(1'b0, 40);
        check(pulses - p0 == 0, "R1 constant low", pulses - p0, 0);
    endtask

    task automatic test_glitch_restart();
        int p0, rise;
        apply(1'b1, 1);
        apply(1'b0, 12);
        apply(1'b1, 3);
        apply(1'b0, 2);
        p0 = pulses;
        apply(1'b1, 20);
        apply(1'b0, 14);
        check(pulses - p0 == 0, "R7 short low after glitch", pulses - p0, 0);
        apply(1'b1, 3);
        apply(1'b0, 8);
        p0 = pulses;
        rise = tick;
        apply(1'b1, 8);
        apply(1'b0, 14);
        check(pulses - p0 == 1, "R7 fresh low after glitch", pulses - p0, 1);
        check(last_pulse_tick - rise == S + H, "R7 latency", last_pulse_tick - rise, S + H);
    endtask

    initial begin
        test_reset();
        test_const_low();
        run_case("R5 nominal", 8, 8, 1);
        run_case("R3 low 7", 7, 12, 0);
        run_case("R3 low 8", 8, 12, 1);
        run_case("R4 high 7", 12, 7, 0);
        run_case("R4 high 8", 12, 8, 1);
        run_case("R6 long high", 20, 40, 1);
        test_glitch_restart();
        run_case("R5 back to back a", 8, 8, 1);
        run_case("R5 back to back b", 8, 8, 1);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule